// File: doc/BRIEF.md
# Descriptor-chained DMA channel engine

This block is one DMA channel. When started it reads a four-word descriptor from memory, giving a next-descriptor pointer, a source address, a target address and a command word. It then copies the byte count held in the command from source to target. Each burst is read into a small internal buffer and then written out. When the count runs out it either stops or loads the next descriptor in the chain. A descriptor pointer can also select an alternate descriptor 32 bytes further on, depending on a compare-status input.

All memory traffic goes through a single request/acknowledge master with byte addresses and right-aligned data. Each access is 1, 2 or 4 bytes wide. A peripheral can pace the copy through a flow-control request input. If that request is withdrawn during a burst, the transfer is cut short and an end-of-receive event is raised. The controlling logic starts the channel with a strobe. It can start it either from a descriptor pointer or directly from source, target and command values, which skips the fetch. Sticky status flags and the live command word, with its remaining length written back, are the outputs.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the engine is idle (`busy` low), `flag_stop` is high, `flag_start`, `flag_end` and `flag_eor` are low, and no memory request is raised while idle.
- R2: The descriptor address is the pointer with its low 4 bits cleared. 32 is added when pointer bit 1 (branch enable) and `cmp_status` are both high.
- R3: The descriptor is read as four 4-byte reads at descriptor address +0, +4, +8 and +12. These give, in order, the next pointer, the source, the target and the command. The command word holds the length in bits 12:0, the width code in 15:14, the burst code in 17:16, end-flag enable in 21, start-flag enable in 22, target flow control in 28, source flow control in 29, target increment in 30 and source increment in 31.
- R4: Each burst moves min(remaining, burst size) bytes, with burst code 0..3 giving 4, 8, 16 or 32 bytes. The burst is done as element reads into the buffer followed by the same number of element writes. Width code 1, 2 or 3 gives 1, 2 or 4 byte elements, and code 0 is treated as 4 bytes. `mem_size` is 0, 1 or 2 for 1, 2 or 4 bytes.
- R5: After each element access the source (or target) address steps by the element width only when bit 31 (or bit 30) is set. Otherwise it stays fixed.
- R6: When a descriptor is loaded with source (or target) flow control enabled, the low 2 bits of that address are cleared.
- R7: `flag_start` is raised when a descriptor whose bit 22 is set is loaded.
- R8: Under flow control (bit 28 or 29), no burst starts while `flow_req` is low.
- R9: Under flow control, if `flow_req` is low when a burst finishes, `flag_eor` is set and the channel stops (`busy` low, `flag_stop` high). This happens even when the chain would continue.
- R10: The remaining length is written back into `cmd_word[12:0]` after each burst. At zero, `flag_end` is set if bit 21 is set. The channel then stops if it was started without descriptor fetch or if pointer bit 0 is set. `flag_stop` is never high while `busy` is high.
- R11: When a descriptor completes with no stop condition, the next descriptor is fetched and the copy continues.
- R12: A memory request keeps its address, direction, size and write data stable until `mem_ready`. It drops in the cycle after the acknowledge, so there is at most one access in flight.
- R13: A start with `start_nofetch` high takes source, target and command from `cfg_src`, `cfg_dst` and `cfg_cmd` and performs no descriptor read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken when idle |
| start_nofetch | input | 1 | With start: use cfg values, skip descriptor fetch |
| cfg_desc | input | 32 | First next-descriptor pointer |
| cfg_src | input | 32 | Source address for no-fetch start |
| cfg_dst | input | 32 | Target address for no-fetch start |
| cfg_cmd | input | 32 | Command word for no-fetch start |
| cmp_status | input | 1 | Compare-status flag used for descriptor branch |
| flow_req | input | 1 | Peripheral flow-control request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size code (0:1B, 1:2B, 2:4B) |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned, valid with mem_ready |
| mem_ready | input | 1 | Access acknowledge |
| busy | output | 1 | Channel running |
| flag_start | output | 1 | Sticky start event |
| flag_end | output | 1 | Sticky end-of-length event |
| flag_stop | output | 1 | Channel stopped |
| flag_eor | output | 1 | Sticky end-of-receive event |
| cmd_word | output | 32 | Current command word with remaining length |

## Verification
The sharpest collision is the end-of-receive cut and the end-of-length completion landing on the same burst. The bench provokes this with a flow-controlled descriptor whose length equals one burst, drops `flow_req` while that burst's writes are in flight, and gives it a next pointer without the stop bit. The expected result is `flag_eor` and `flag_end` both set, the channel stopped, zero remaining length, and no further descriptor read counted on the memory model. A second overlap, the branch offset against the stop bit, is judged by which of two target areas receives data.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ARM,
    ST_READ,
    ST_WRITE,
    ST_POST
  } eng_state_t;

  // command word field positions
  localparam int CW_LEN_W    = 13;
  localparam int CW_WID_LO   = 14;
  localparam int CW_BST_LO   = 16;
  localparam int CW_END_IE   = 21;
  localparam int CW_START_IE = 22;
  localparam int CW_FLOW_DST = 28;
  localparam int CW_FLOW_SRC = 29;
  localparam int CW_INC_DST  = 30;
  localparam int CW_INC_SRC  = 31;

  // next-pointer flag positions
  localparam int NP_STOP   = 0;
  localparam int NP_BRANCH = 1;

  // element width code to log2 of bytes; code 0 falls back to 4 bytes
  function automatic logic [1:0] width_log2(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd0;
      2'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/dma_desc_addr.sv
module dma_desc_addr
  import dma_chan_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BRANCH_OFS = 32
) (
  input  logic [AW-1:0] next_ptr,
  input  logic          cmp_flag,
  output logic [AW-1:0] desc_base
);

  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(15);

  always_comb begin
    desc_base = next_ptr & ALIGN_MASK;
    if (next_ptr[NP_BRANCH] && cmp_flag)
      desc_base = desc_base + AW'(BRANCH_OFS);
  end

endmodule

// File: rtl/dma_burst_sizer.sv
module dma_burst_sizer
  import dma_chan_pkg::*;
#(
  parameter int LEN_W     = 13,
  parameter int BUF_BYTES = 32,
  parameter int IDX_W     = 6
) (
  input  logic [LEN_W-1:0] remain,
  input  logic [1:0]       wid_code,
  input  logic [1:0]       bst_code,
  output logic [1:0]       wlog,
  output logic [LEN_W-1:0] pass_bytes,
  output logic [IDX_W-1:0] elem_cnt
);

  logic [LEN_W-1:0] bsize;
  logic [LEN_W-1:0] rounded;

  always_comb begin
    wlog  = width_log2(wid_code);
    bsize = LEN_W'(4) << bst_code;
    if (bsize > LEN_W'(BUF_BYTES))
      bsize = LEN_W'(BUF_BYTES);
    pass_bytes = (remain < bsize) ? remain : bsize;
    rounded    = pass_bytes + ((LEN_W'(1) << wlog) - LEN_W'(1));
    elem_cnt   = IDX_W'(rounded >> wlog);
  end

endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int AIW   = 5
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AIW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [AIW-1:0] raddr,
  output logic [DW-1:0]  rdata
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LEN_W      = CW_LEN_W,
  parameter int BUF_BYTES  = 32,
  parameter int BRANCH_OFS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_nofetch,
  input  logic [AW-1:0] cfg_desc,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [DW-1:0] cfg_cmd,
  input  logic          cmp_status,
  input  logic          flow_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          flag_start,
  output logic          flag_end,
  output logic          flag_stop,
  output logic          flag_eor,
  output logic [DW-1:0] cmd_word
);

  localparam int IDX_W = $clog2(BUF_BYTES + 1);
  localparam int AIW   = $clog2(BUF_BYTES);

  eng_state_t       state;
  logic [AW-1:0]    desc_ptr;
  logic [AW-1:0]    fetch_base;
  logic [AW-1:0]    src_a;
  logic [AW-1:0]    dst_a;
  logic [DW-1:0]    cmd;
  logic             nofetch;
  logic [1:0]       widx;
  logic [IDX_W-1:0] elem;
  logic [IDX_W-1:0] nelem_r;
  logic [LEN_W-1:0] bbytes_r;

  logic [AW-1:0]    ptr_sel;
  logic [AW-1:0]    desc_base;
  logic [1:0]       wlog;
  logic [LEN_W-1:0] pass_bytes;
  logic [IDX_W-1:0] elem_cnt;
  logic [AW-1:0]    wstep;
  logic             acc_done;
  logic             flow_en;
  logic [LEN_W-1:0] post_len;
  logic             eor_hit;
  logic             buf_we;
  logic [DW-1:0]    buf_rd;

  assign ptr_sel  = (state == ST_IDLE) ? cfg_desc : desc_ptr;
  assign wstep    = AW'(1) << wlog;
  assign acc_done = mem_req && mem_ready;
  assign flow_en  = cmd[CW_FLOW_DST] || cmd[CW_FLOW_SRC];
  assign post_len = cmd[LEN_W-1:0] - bbytes_r;
  assign eor_hit  = flow_en && !flow_req && (bbytes_r != '0);
  assign buf_we   = (state == ST_READ) && acc_done;
  assign cmd_word = cmd;

  dma_desc_addr #(.AW(AW), .BRANCH_OFS(BRANCH_OFS)) u_addr (
    .next_ptr  (ptr_sel),
    .cmp_flag  (cmp_status),
    .desc_base (desc_base)
  );

  dma_burst_sizer #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) u_sizer (
    .remain     (cmd[LEN_W-1:0]),
    .wid_code   (cmd[CW_WID_LO +: 2]),
    .bst_code   (cmd[CW_BST_LO +: 2]),
    .wlog       (wlog),
    .pass_bytes (pass_bytes),
    .elem_cnt   (elem_cnt)
  );

  dma_burst_buf #(.DW(DW), .DEPTH(BUF_BYTES), .AIW(AIW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (elem[AIW-1:0]),
    .wdata (mem_rdata),
    .raddr (elem[AIW-1:0]),
    .rdata (buf_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      desc_ptr   <= '0;
      fetch_base <= '0;
      src_a      <= '0;
      dst_a      <= '0;
      cmd        <= '0;
      nofetch    <= 1'b0;
      widx       <= '0;
      elem       <= '0;
      nelem_r    <= '0;
      bbytes_r   <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_size   <= 2'd0;
      mem_wdata  <= '0;
      busy       <= 1'b0;
      flag_start <= 1'b0;
      flag_end   <= 1'b0;
      flag_stop  <= 1'b1;
      flag_eor   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            busy       <= 1'b1;
            flag_stop  <= 1'b0;
            flag_start <= 1'b0;
            flag_end   <= 1'b0;
            flag_eor   <= 1'b0;
            nofetch    <= start_nofetch;
            if (start_nofetch) begin
              src_a <= cfg_src;
              dst_a <= cfg_dst;
              cmd   <= cfg_cmd;
              state <= ST_ARM;
            end else begin
              fetch_base <= desc_base;
              widx       <= '0;
              state      <= ST_FETCH;
            end
          end
        end

        ST_FETCH: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= fetch_base + AW'({widx, 2'b00});
            mem_size <= 2'd2;
          end else if (mem_ready) begin
            mem_req <= 1'b0;
            widx    <= widx + 2'd1;
            case (widx)
              2'd0: desc_ptr <= mem_rdata;
              2'd1: src_a    <= mem_rdata;
              2'd2: dst_a    <= mem_rdata;
              default: begin
                cmd <= mem_rdata;
                if (mem_rdata[CW_FLOW_SRC]) src_a <= {src_a[AW-1:2], 2'b00};
                if (mem_rdata[CW_FLOW_DST]) dst_a <= {dst_a[AW-1:2], 2'b00};
                if (mem_rdata[CW_START_IE]) flag_start <= 1'b1;
                state <= ST_ARM;
              end
            endcase
          end
        end

        ST_ARM: begin
          if (cmd[LEN_W-1:0] == '0) begin
            bbytes_r <= '0;
            state    <= ST_POST;
          end else if (!(flow_en && !flow_req)) begin
            bbytes_r <= pass_bytes;
            nelem_r  <= elem_cnt;
            elem     <= '0;
            state    <= ST_READ;
          end
        end

        ST_READ: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= src_a;
            mem_size <= wlog;
          end else if (mem_ready) begin
            mem_req <= 1'b0;
            if (cmd[CW_INC_SRC]) src_a <= src_a + wstep;
            if (elem == nelem_r - IDX_W'(1)) begin
              elem  <= '0;
              state <= ST_WRITE;
            end else begin
              elem <= elem + IDX_W'(1);
            end
          end
        end

        ST_WRITE: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= dst_a;
            mem_size  <= wlog;
            mem_wdata <= buf_rd;
          end else if (mem_ready) begin
            mem_req <= 1'b0;
            if (cmd[CW_INC_DST]) dst_a <= dst_a + wstep;
            if (elem == nelem_r - IDX_W'(1)) begin
              elem  <= '0;
              state <= ST_POST;
            end else begin
              elem <= elem + IDX_W'(1);
            end
          end
        end

        ST_POST: begin
          cmd[LEN_W-1:0] <= post_len;
          if (eor_hit) flag_eor <= 1'b1;
          if (post_len == '0 && cmd[CW_END_IE]) flag_end <= 1'b1;
          if (eor_hit || (post_len == '0 && (nofetch || desc_ptr[NP_STOP]))) begin
            busy      <= 1'b0;
            flag_stop <= 1'b1;
            state     <= ST_IDLE;
          end else if (post_len == '0) begin
            fetch_base <= desc_base;
            widx       <= '0;
            state      <= ST_FETCH;
          end else begin
            state <= ST_ARM;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_engine_checker.sv
module dma_chan_engine_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          flag_stop,
  input logic          flag_eor,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic [DW-1:0] mem_wdata
);

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_size) && $stable(mem_wdata));

  assert_drop_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ready |=> !mem_req);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  assert_size_code_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_size != 2'b11);

  assert_stop_excl_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !flag_stop);

  assert_eor_halts_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_eor) |-> flag_stop && !busy);

endmodule

bind dma_chan_engine dma_chan_engine_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .flag_stop (flag_stop),
  .flag_eor  (flag_eor),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_size  (mem_size),
  .mem_wdata (mem_wdata)
);

// File: tb/dma_chan_engine_bench.sv
`timescale 1ns/1ps
module dma_chan_engine_bench;

  localparam int MEM_BYTES = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        start_nofetch = 1'b0;
  logic [31:0] cfg_desc = '0, cfg_src = '0, cfg_dst = '0, cfg_cmd = '0;
  logic        cmp_status = 1'b0;
  logic        flow_req = 1'b1;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        busy, flag_start, flag_end, flag_stop, flag_eor;
  logic [31:0] cmd_word;

  logic [7:0]  mem [MEM_BYTES];
  logic        rdy;
  logic        bw_en = 1'b0;
  logic [31:0] bw_addr = '0, bw_data = '0;
  int          acc_cnt, viol;
  logic [31:0] acc_log;
  logic        p_req, p_rdy, p_we;
  logic [31:0] p_addr;
  int          checks = 0, fails = 0;
  int          base_cnt;

  always #10 clk = ~clk;

  dma_chan_engine u_dma_chan_engine (
    .clk(clk), .rst(rst), .start(start), .start_nofetch(start_nofetch),
    .cfg_desc(cfg_desc), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cmd(cfg_cmd),
    .cmp_status(cmp_status), .flow_req(flow_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .flag_start(flag_start), .flag_end(flag_end),
    .flag_stop(flag_stop), .flag_eor(flag_eor), .cmd_word(cmd_word)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [10:0] ix(input logic [31:0] a, input int k);
    return 11'(a + 32'(k));
  endfunction

  assign mem_ready = rdy;
  assign mem_rdata = {mem[ix(mem_addr, 3)], mem[ix(mem_addr, 2)],
                      mem[ix(mem_addr, 1)], mem[ix(mem_addr, 0)]};

  // memory model: one-cycle acknowledge, byte array, access log
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= pat(i);
      rdy <= 1'b0; acc_cnt <= 0; acc_log <= '0; viol <= 0;
      p_req <= 1'b0; p_rdy <= 1'b0; p_we <= 1'b0; p_addr <= '0;
    end else begin
      rdy <= mem_req && !rdy;
      if (bw_en)
        for (int k = 0; k < 4; k++) mem[ix(bw_addr, k)] <= bw_data[8*k +: 8];
      if (mem_req && rdy) begin
        acc_cnt <= acc_cnt + 1;
        acc_log <= {acc_log[30:0], mem_we};
        if (mem_we)
          for (int k = 0; k < (1 << mem_size); k++)
            mem[ix(mem_addr, k)] <= mem_wdata[8*k +: 8];
      end
      if (p_req && !p_rdy && (!mem_req || mem_addr != p_addr || mem_we != p_we))
        viol <= viol + 1;
      p_req <= mem_req; p_rdy <= rdy; p_we <= mem_we; p_addr <= mem_addr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_w(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bw_en = 1'b1; bw_addr = a; bw_data = d;
    @(negedge clk); bw_en = 1'b0;
  endtask

  task automatic clear(input logic [31:0] a, input int nwords);
    for (int i = 0; i < nwords; i++) put_w(a + 32'(4 * i), 32'h0);
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] np,
                          input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    put_w(a, np); put_w(a + 4, s); put_w(a + 8, d); put_w(a + 12, c);
  endtask

  function automatic logic [31:0] mkcmd(input int len, input int wc, input int bc,
      input bit endi, input bit starti, input bit fdst, input bit fsrc,
      input bit idst, input bit isrc);
    logic [31:0] c;
    c = 32'(len) & 32'h1FFF;
    c[15:14] = 2'(wc); c[17:16] = 2'(bc);
    c[21] = endi; c[22] = starti; c[28] = fdst; c[29] = fsrc;
    c[30] = idst; c[31] = isrc;
    return c;
  endfunction

  task automatic launch(input bit nf, input logic [31:0] dp, input logic [31:0] s,
                        input logic [31:0] d, input logic [31:0] c);
    @(negedge clk);
    base_cnt = acc_cnt;
    start_nofetch = nf; cfg_desc = dp; cfg_src = s; cfg_dst = d; cfg_cmd = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic chk_copy(input string req, input logic [31:0] s, input logic [31:0] d, input int n);
    for (int i = 0; i < n; i++) chk(req, 32'(mem[ix(d, i)]), 32'(pat(int'(s) + i)));
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 stop", 32'(flag_stop), 1);
    chk("R1 other flags", {29'b0, flag_start, flag_end, flag_eor}, 0);
    chk("R1 mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_basic();
    clear(32'h300, 4);
    put_desc(32'h100, 32'h1, 32'h200, 32'h300, mkcmd(12, 3, 0, 1, 1, 0, 0, 1, 1));
    launch(0, 32'h100, 0, 0, 0);
    wait_idle();
    chk_copy("R3 copy", 32'h200, 32'h300, 12);
    chk("R5 beyond end untouched", 32'(mem[ix(32'h300, 12)]), 0);
    chk("R7 start flag", 32'(flag_start), 1);
    chk("R10 end flag", 32'(flag_end), 1);
    chk("R10 stop", {30'b0, flag_stop, busy}, 32'h2);
    chk("R10 length written back", {19'b0, cmd_word[12:0]}, 0);
    chk("R3 access count", 32'(acc_cnt - base_cnt), 10);
  endtask

  task automatic t_bytes_fixed_dst();
    clear(32'h340, 2);
    put_desc(32'h120, 32'h1, 32'h2C0, 32'h340, mkcmd(6, 1, 0, 0, 0, 0, 0, 0, 1));
    launch(0, 32'h120, 0, 0, 0);
    wait_idle();
    chk("R4 access count", 32'(acc_cnt - base_cnt), 16);
    chk("R4 read-then-write order", acc_log & 32'hFFFF, 32'h00F3);
    chk("R5 fixed target last byte", 32'(mem[ix(32'h340, 0)]), 32'(pat(32'h2C5)));
    chk("R5 fixed target next byte", 32'(mem[ix(32'h340, 1)]), 0);
    chk("R7 start disabled", 32'(flag_start), 0);
    chk("R10 end disabled", 32'(flag_end), 0);
  endtask

  task automatic t_chain();
    clear(32'h380, 8);
    put_desc(32'h140, 32'h160, 32'h210, 32'h380, mkcmd(4, 3, 0, 0, 0, 0, 0, 1, 1));
    put_desc(32'h160, 32'h1, 32'h220, 32'h390, mkcmd(4, 3, 0, 1, 0, 0, 0, 1, 1));
    launch(0, 32'h140, 0, 0, 0);
    wait_idle();
    chk_copy("R11 first link", 32'h210, 32'h380, 4);
    chk_copy("R11 second link", 32'h220, 32'h390, 4);
    chk("R11 access count", 32'(acc_cnt - base_cnt), 12);
    chk("R11 end flag", 32'(flag_end), 1);
  endtask

  task automatic t_branch();
    clear(32'h3A0, 8);
    put_desc(32'h400, 32'h1, 32'h230, 32'h3A0, mkcmd(4, 3, 0, 0, 0, 0, 0, 1, 1));
    put_desc(32'h420, 32'h1, 32'h240, 32'h3B0, mkcmd(4, 3, 0, 0, 0, 0, 0, 1, 1));
    cmp_status = 1'b1;
    launch(0, 32'h40A, 0, 0, 0);
    wait_idle();
    chk_copy("R2 branch taken", 32'h240, 32'h3B0, 4);
    chk("R2 base not used", {mem[ix(32'h3A0, 3)], mem[ix(32'h3A0, 2)],
                             mem[ix(32'h3A0, 1)], mem[ix(32'h3A0, 0)]}, 0);
    cmp_status = 1'b0;
    launch(0, 32'h40A, 0, 0, 0);
    wait_idle();
    chk_copy("R2 branch not taken", 32'h230, 32'h3A0, 4);
  endtask

  task automatic t_nofetch();
    clear(32'h3C0, 2);
    launch(1, 32'h0, 32'h250, 32'h3C0, mkcmd(8, 3, 1, 1, 0, 0, 0, 1, 1));
    wait_idle();
    chk("R13 access count", 32'(acc_cnt - base_cnt), 4);
    chk("R13 access order", acc_log & 32'hF, 32'h3);
    chk_copy("R13 copy", 32'h250, 32'h3C0, 8);
    chk("R13 end and stop", {30'b0, flag_end, flag_stop}, 32'h3);
  endtask

  task automatic t_width0();
    clear(32'h3C8, 2);
    launch(1, 32'h0, 32'h2A0, 32'h3C8, mkcmd(8, 0, 1, 0, 0, 0, 0, 1, 1));
    wait_idle();
    chk("R4 width code 0 access count", 32'(acc_cnt - base_cnt), 4);
    chk_copy("R4 width code 0 copy", 32'h2A0, 32'h3C8, 8);
  endtask

  task automatic t_flow_wait();
    clear(32'h3D0, 2);
    put_desc(32'h180, 32'h1, 32'h263, 32'h3D0, mkcmd(4, 3, 0, 0, 0, 0, 1, 1, 1));
    flow_req = 1'b0;
    launch(0, 32'h180, 0, 0, 0);
    repeat (40) @(negedge clk);
    chk("R8 still busy while request low", 32'(busy), 1);
    chk("R8 only descriptor reads", 32'(acc_cnt - base_cnt), 4);
    flow_req = 1'b1;
    wait_idle();
    chk_copy("R6 aligned source", 32'h260, 32'h3D0, 4);
    chk("R8 no end-of-receive", 32'(flag_eor), 0);
  endtask

  task automatic t_eor_cut();
    clear(32'h3E0, 4);
    put_desc(32'h1A0, 32'h1, 32'h270, 32'h3E0, mkcmd(16, 3, 0, 1, 0, 1, 0, 1, 1));
    flow_req = 1'b1;
    launch(0, 32'h1A0, 0, 0, 0);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (mem_req && mem_we) break;
    end
    flow_req = 1'b0;
    wait_idle();
    chk("R9 eor flag", 32'(flag_eor), 1);
    chk("R9 stopped", {30'b0, flag_stop, busy}, 32'h2);
    chk("R9 remaining length", {19'b0, cmd_word[12:0]}, 12);
    chk_copy("R9 first burst", 32'h270, 32'h3E0, 4);
    chk("R9 second burst absent", {mem[ix(32'h3E4, 3)], mem[ix(32'h3E4, 2)],
                                   mem[ix(32'h3E4, 1)], mem[ix(32'h3E4, 0)]}, 0);
    chk("R9 no end flag", 32'(flag_end), 0);
    flow_req = 1'b1;
  endtask

  task automatic t_eor_and_end();
    clear(32'h3F0, 2);
    put_desc(32'h1C0, 32'h160, 32'h280, 32'h3F0, mkcmd(4, 3, 0, 1, 0, 0, 1, 1, 1));
    flow_req = 1'b1;
    launch(0, 32'h1C0, 0, 0, 0);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (mem_req && mem_we) break;
    end
    flow_req = 1'b0;
    wait_idle();
    chk("R9 eor with end", {30'b0, flag_eor, flag_end}, 32'h3);
    chk("R10 stop wins over chain", {30'b0, flag_stop, busy}, 32'h2);
    chk("R11 no next fetch", 32'(acc_cnt - base_cnt), 6);
    chk("R10 length zero", {19'b0, cmd_word[12:0]}, 0);
    flow_req = 1'b1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bytes_fixed_dst();
    t_chain();
    t_branch();
    t_nofetch();
    t_width0();
    t_flow_wait();
    t_eor_cut();
    t_eor_and_end();
    chk("R12 handshake stability", 32'(viol), 0);
    summary();
    $finish;
  end

endmodule